// File: doc/BRIEF.md
# Streaming Cache Line Prefetcher

This block sits beside a cache hierarchy and watches the demand read addresses that reach it. Inside each 4 KB physical page it looks for runs of demands that step one 64-byte line at a time, either upwards or downwards. Once a run is confirmed, every further demand on that run produces up to two prefetch requests for the next lines in the same direction. Prefetches never leave the page of the demand that caused them.

A table of stream entries, 32 by default, holds the state of each run. A page may have one ascending and one descending run at the same time. When the table is full, a new page takes over the least recently used entry. An outstanding-request count from the memory side sets the maximum distance between the newest prefetched line and the current demand line, and it sets the cache level each prefetch targets: mid level (and last level), or last level only.

Prefetch requests leave through a valid/ready port. A small FIFO buffers them. When the FIFO has no room, extra candidates are dropped, so demand observation never stalls.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset no prefetch is offered (`pf_valid` low) and `dmd_ready` is high.
- R2: The first demand to a page issues no prefetch. A second demand to the line directly above or below the previous demand in that page trains a stream in that direction. The training demand itself issues prefetches starting at the line one step beyond it.
- R3: Each demand that hits a trained ascending stream (line = previous demand line + 1) issues up to two prefetches, for consecutive line addresses, nearer one first. They start at the stream's next unprefetched line, or at demand+1 if the demand has caught up with it. `pf_addr` is line-aligned: bits [5:0] are zero, bits [11:6] hold the line within the page, and the upper bits hold the page.
- R4: Descending streams behave like R3 with a step of -1 line.
- R5: No prefetch addresses a line outside 0..63 of the triggering demand's page.
- R6: With outstanding count below LO_TH (default 4), a prefetch's distance from the demand line is at most 20 lines. Once that distance is reached, the stream issues nothing until demands advance.
- R7: With outstanding count from LO_TH to HI_TH-1 (default 4..11), the distance is at most 10 lines, and `pf_llc_only` is 0.
- R8: With outstanding count at or above HI_TH (default 12), the distance is at most 4 lines, and every prefetch has `pf_llc_only` = 1.
- R9: Under low load, a prefetch more than 10 lines ahead of its demand has `pf_llc_only` = 1. Otherwise it is 0.
- R10: One ascending and one descending stream can be trained in the same page and used interleaved, each keeping its own progress.
- R11: With all entries in use, a demand to an untracked page replaces the least recently used entry. A replaced stream must retrain before it prefetches again.
- R12: While `pf_ready` is low, up to 4 prefetches are held in order, and the head request stays stable. Further candidates are dropped, and `dmd_ready` stays high. Dropped lines are not reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmd_valid | input | 1 | Demand address valid |
| dmd_ready | output | 1 | Demand accepted (always high) |
| dmd_addr | input | AW | Demand byte address |
| outstanding | input | CW | Current outstanding-request count |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_addr | output | AW | Prefetch line-aligned byte address |
| pf_llc_only | output | 1 | 1: fill last-level cache only; 0: mid level too |

## Verification
The bench builds the block with a 4-entry stream table, so eviction and least-recently-used order can be reached after a handful of pages. All other parameters keep their defaults. Full-page ascending and descending walks are swept across every outstanding count from 0 to 15, which covers the 20, 10 and 4 line limits, the far-ahead level flag and both page edges. Expected prefetch lists come from arithmetic on the demand line and the stream's next pointer.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int LINE_B = 6;
  localparam int OFF_W  = 6;
  localparam int PAGE_B = LINE_B + OFF_W;
  localparam int PAGE_LINES = 1 << OFF_W;

  typedef logic signed [OFF_W+2:0] soff_t;

  typedef enum logic [1:0] {
    LOAD_LIGHT,
    LOAD_MEDIUM,
    LOAD_HEAVY
  } load_e;
endpackage

// File: rtl/sp_load_policy.sv
module sp_load_policy
  import sp_pkg::*;
#(
  parameter int CW        = 5,
  parameter int LO_TH     = 4,
  parameter int HI_TH     = 12,
  parameter int LOW_DIST  = 20,
  parameter int MID_DIST  = 10,
  parameter int HIGH_DIST = 4,
  parameter int LIM_W     = 7
) (
  input  logic [CW-1:0]    outstanding,
  output logic [LIM_W-1:0] limit,
  output logic             all_llc
);
  load_e lvl;

  always_comb begin
    if (outstanding < CW'(LO_TH))      lvl = LOAD_LIGHT;
    else if (outstanding < CW'(HI_TH)) lvl = LOAD_MEDIUM;
    else                               lvl = LOAD_HEAVY;
  end

  always_comb begin
    unique case (lvl)
      LOAD_LIGHT:  begin limit = LIM_W'(LOW_DIST);  all_llc = 1'b0; end
      LOAD_MEDIUM: begin limit = LIM_W'(MID_DIST);  all_llc = 1'b0; end
      default:     begin limit = LIM_W'(HIGH_DIST); all_llc = 1'b1; end
    endcase
  end
endmodule

// File: rtl/sp_stream_table.sv
module sp_stream_table
  import sp_pkg::*;
#(
  parameter int NS    = 32,
  parameter int PW    = 20,
  parameter int LIM_W = 7,
  localparam int IW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dmd_fire,
  input  logic [PW-1:0]    dmd_page,
  input  logic [OFF_W-1:0] dmd_line,
  input  logic [LIM_W-1:0] limit,
  output logic [1:0]       cand_v,
  output logic [OFF_W-1:0] cand_line0,
  output logic [OFF_W-1:0] cand_line1,
  output logic [LIM_W-1:0] cand_dist0,
  output logic [LIM_W-1:0] cand_dist1
);
  logic [NS-1:0]    ent_v, ent_tr, ent_dn;
  logic [PW-1:0]    ent_pg   [NS];
  logic [OFF_W-1:0] ent_last [NS];
  soff_t            ent_ptr  [NS];
  logic [IW-1:0]    ent_age  [NS];

  logic          th_hit, uh_hit, has_free;
  logic [IW-1:0] th_idx, uh_idx, free_idx, vic_idx, touch_idx;
  logic [NS-1:0] up_in_pg, dn_in_pg, is_oldest;
  soff_t         line_s, uh_ls, step, base, c0, c1, d0, d1, lim_s, new_ptr;
  logic          adj_up, adj_dn, learn, gen, g_dn, ahead, ok0, ok1;

  assign line_s = soff_t'({3'b000, dmd_line});
  assign lim_s  = soff_t'({{(OFF_W+3-LIM_W){1'b0}}, limit});

  // Table lookup: lowest index wins on every search.
  always_comb begin
    th_hit = 1'b0; th_idx = '0; uh_hit = 1'b0; uh_idx = '0;
    has_free = 1'b0; free_idx = '0; vic_idx = '0;
    up_in_pg = '0; dn_in_pg = '0; is_oldest = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      logic  pm;
      soff_t ls;
      pm = ent_v[i] && (ent_pg[i] == dmd_page);
      ls = soff_t'({3'b000, ent_last[i]});
      if (pm && ent_tr[i] &&
          (ent_dn[i] ? (line_s == ls - 9'sd1) : (line_s == ls + 9'sd1))) begin
        th_hit = 1'b1; th_idx = IW'(i);
      end
      if (pm && !ent_tr[i]) begin
        uh_hit = 1'b1; uh_idx = IW'(i);
      end
      up_in_pg[i] = pm && ent_tr[i] && !ent_dn[i];
      dn_in_pg[i] = pm && ent_tr[i] && ent_dn[i];
      if (!ent_v[i]) begin
        has_free = 1'b1; free_idx = IW'(i);
      end
      is_oldest[i] = (ent_age[i] == IW'(NS - 1));
      if (is_oldest[i]) vic_idx = IW'(i);
    end
  end

  // Decide training and generate the candidate pair.
  always_comb begin
    uh_ls  = soff_t'({3'b000, ent_last[uh_idx]});
    adj_up = uh_hit && (line_s == uh_ls + 9'sd1) && (up_in_pg == '0);
    adj_dn = uh_hit && (line_s == uh_ls - 9'sd1) && (dn_in_pg == '0);
    learn  = !th_hit && (adj_up || adj_dn);
    gen    = dmd_fire && (th_hit || learn);
    g_dn   = th_hit ? ent_dn[th_idx] : adj_dn;
    step   = g_dn ? -9'sd1 : 9'sd1;
    ahead  = th_hit && (g_dn ? (ent_ptr[th_idx] < line_s) : (ent_ptr[th_idx] > line_s));
    base   = ahead ? ent_ptr[th_idx] : line_s + step;
    c0     = base;
    c1     = base + step;
    d0     = g_dn ? line_s - c0 : c0 - line_s;
    d1     = g_dn ? line_s - c1 : c1 - line_s;
    ok0    = gen && (c0 >= 9'sd0) && (c0 < 9'sd64) && (d0 <= lim_s);
    ok1    = ok0 && (c1 >= 9'sd0) && (c1 < 9'sd64) && (d1 <= lim_s);
    new_ptr = ok1 ? c1 + step : (ok0 ? c0 + step : base);
    touch_idx = th_hit ? th_idx : (uh_hit ? uh_idx : (has_free ? free_idx : vic_idx));
  end

  assign cand_v     = {ok1, ok0};
  assign cand_line0 = c0[OFF_W-1:0];
  assign cand_line1 = c1[OFF_W-1:0];
  assign cand_dist0 = d0[LIM_W-1:0];
  assign cand_dist1 = d1[LIM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      for (int j = 0; j < NS; j++) ent_age[j] <= IW'(j);
    end else if (dmd_fire) begin
      if (th_hit) begin
        ent_last[th_idx] <= dmd_line;
        ent_ptr[th_idx]  <= new_ptr;
      end else if (uh_hit) begin
        ent_last[uh_idx] <= dmd_line;
        if (learn) begin
          ent_tr[uh_idx]  <= 1'b1;
          ent_dn[uh_idx]  <= adj_dn;
          ent_ptr[uh_idx] <= new_ptr;
        end
      end else begin
        ent_v[touch_idx]    <= 1'b1;
        ent_tr[touch_idx]   <= 1'b0;
        ent_dn[touch_idx]   <= 1'b0;
        ent_pg[touch_idx]   <= dmd_page;
        ent_last[touch_idx] <= dmd_line;
        ent_ptr[touch_idx]  <= '0;
      end
      for (int j = 0; j < NS; j++) begin
        if (IW'(j) == touch_idx)                 ent_age[j] <= '0;
        else if (ent_age[j] < ent_age[touch_idx]) ent_age[j] <= ent_age[j] + 1'b1;
      end
    end
  end

  // R10: a page never holds two trained streams of the same direction.
  a_r10_one_per_dir: assert property (@(posedge clk) disable iff (rst)
    ($countones(up_in_pg) <= 1) && ($countones(dn_in_pg) <= 1));

  // R11: recency ranks stay a permutation, so exactly one entry is oldest.
  a_r11_single_victim: assert property (@(posedge clk) disable iff (rst)
    $countones(is_oldest) == 1);

  // R5: a table write always leaves the trained stream's pointer in range.
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (rst)
    (dmd_fire && th_hit) |=> (ent_ptr[$past(th_idx)] >= -9'sd1) &&
                              (ent_ptr[$past(th_idx)] <= 9'sd64));
endmodule

// File: rtl/sp_pf_fifo.sv
module sp_pf_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 27,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push_v,
  input  logic [DW-1:0] push_d0,
  input  logic [DW-1:0] push_d1,
  input  logic          pop,
  output logic          out_v,
  output logic [DW-1:0] out_d
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, space;
  logic             take0, take1, do_pop;
  logic [1:0]       n_push;

  assign space  = CNT_W'(DEPTH) - count;
  assign take0  = push_v[0] && (space != '0);
  assign take1  = push_v[1] && (take0 ? (space >= CNT_W'(2)) : (space != '0));
  assign n_push = {1'b0, take0} + {1'b0, take1};
  assign do_pop = pop && (count != '0);
  assign out_v  = (count != '0);
  assign out_d  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take0) mem[wr_ptr] <= push_d0;
    if (take1) mem[wr_ptr + PTR_W'(take0)] <= push_d1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(n_push);
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(n_push) - CNT_W'(do_pop);
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r12_head_hold: assert property (@(posedge clk) disable iff (rst)
    (out_v && !pop) |=> (out_v && $stable(out_d)));
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import sp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 5,
  parameter int NS        = 32,
  parameter int FIFO_D    = 4,
  parameter int LO_TH     = 4,
  parameter int HI_TH     = 12,
  parameter int LOW_DIST  = 20,
  parameter int MID_DIST  = 10,
  parameter int HIGH_DIST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dmd_valid,
  output logic          dmd_ready,
  input  logic [AW-1:0] dmd_addr,
  input  logic [CW-1:0] outstanding,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr,
  output logic          pf_llc_only
);
  localparam int PW    = AW - PAGE_B;
  localparam int LAW   = AW - LINE_B;
  localparam int DW    = LAW + 1;
  localparam int LIM_W = 7;

  logic             dmd_fire, all_llc, llc0, llc1, unused_lo;
  logic [PW-1:0]    dmd_page;
  logic [OFF_W-1:0] dmd_line, cand_line0, cand_line1;
  logic [LIM_W-1:0] limit, cand_dist0, cand_dist1;
  logic [1:0]       cand_v;
  logic [DW-1:0]    q_d;

  assign dmd_ready = 1'b1;
  assign dmd_fire  = dmd_valid;
  assign dmd_page  = dmd_addr[AW-1:PAGE_B];
  assign dmd_line  = dmd_addr[PAGE_B-1:LINE_B];
  assign unused_lo = ^dmd_addr[LINE_B-1:0];

  sp_load_policy #(
    .CW(CW), .LO_TH(LO_TH), .HI_TH(HI_TH), .LOW_DIST(LOW_DIST),
    .MID_DIST(MID_DIST), .HIGH_DIST(HIGH_DIST), .LIM_W(LIM_W)
  ) u_load (
    .outstanding(outstanding),
    .limit      (limit),
    .all_llc    (all_llc)
  );

  sp_stream_table #(.NS(NS), .PW(PW), .LIM_W(LIM_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .dmd_fire  (dmd_fire),
    .dmd_page  (dmd_page),
    .dmd_line  (dmd_line),
    .limit     (limit),
    .cand_v    (cand_v),
    .cand_line0(cand_line0),
    .cand_line1(cand_line1),
    .cand_dist0(cand_dist0),
    .cand_dist1(cand_dist1)
  );

  assign llc0 = all_llc || (cand_dist0 > LIM_W'(MID_DIST));
  assign llc1 = all_llc || (cand_dist1 > LIM_W'(MID_DIST));

  sp_pf_fifo #(.DEPTH(FIFO_D), .DW(DW)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .push_v (cand_v),
    .push_d0({llc0, dmd_page, cand_line0}),
    .push_d1({llc1, dmd_page, cand_line1}),
    .pop    (pf_ready),
    .out_v  (pf_valid),
    .out_d  (q_d)
  );

  assign pf_llc_only = q_d[DW-1];
  assign pf_addr     = {q_d[LAW-1:0], {LINE_B{1'b0}}};

  // R3: the far candidate only exists when the near one does.
  a_r3_pair_order: assert property (@(posedge clk) disable iff (rst)
    cand_v[1] |-> cand_v[0]);

  // R6: no candidate lies behind the demand or past the widest window.
  a_r6_span: assert property (@(posedge clk) disable iff (rst)
    cand_v[0] |-> (cand_dist0 >= LIM_W'(1)) && (cand_dist0 <= LIM_W'(LOW_DIST)));

  // R1: the cycle after a reset shows no prefetch.
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !pf_valid);
endmodule

// File: tb/stream_prefetcher_tb.sv
`timescale 1ns/1ps
module stream_prefetcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dmd_valid = 1'b0;
  logic        dmd_ready;
  logic [31:0] dmd_addr = '0;
  logic [4:0]  outstanding = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;
  logic        pf_llc_only;

  int vectors = 0;
  int miscmp  = 0;
  int next_pg = 5;

  int cap_pg[64], cap_ln[64], exp_pg[64], exp_ln[64];
  bit cap_llc[64], exp_llc[64];
  int ncap = 0, nexp = 0;

  always #2.5 clk = ~clk;

  stream_prefetcher #(.NS(4)) u_dut (
    .clk(clk), .rst(rst), .dmd_valid(dmd_valid), .dmd_ready(dmd_ready),
    .dmd_addr(dmd_addr), .outstanding(outstanding), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_llc_only(pf_llc_only)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && pf_valid && pf_ready && ncap < 64) begin
      cap_pg[ncap]  = int'(pf_addr[31:12]);
      cap_ln[ncap]  = int'(pf_addr[11:6]);
      cap_llc[ncap] = pf_llc_only;
      chk(pf_addr[5:0] == 6'd0, "R3", "pf_addr low bits", int'(pf_addr[5:0]), 0);
      ncap++;
    end
  end

  task automatic demand(input int pg, input int ln);
    @(posedge clk); #1;
    dmd_valid = 1'b1;
    dmd_addr  = {pg[19:0], ln[5:0], 6'd0};
    @(posedge clk); #1;
    dmd_valid = 1'b0;
    repeat (5) @(posedge clk);
    #1;
  endtask

  // Arithmetic model of one stream step, from the requirements.
  task automatic model(input int pg, input int L, input int s, input bit trained,
                       inout int ptr);
    int lim, base, n, c, d;
    bit force_llc;
    lim = (outstanding < 4) ? 20 : (outstanding < 12) ? 10 : 4;
    force_llc = (outstanding >= 12);
    base = (trained && (ptr - L) * s > 0) ? ptr : L + s;
    n = 0;
    for (int k = 0; k < 2; k++) begin
      c = base + k * s;
      d = (c - L) * s;
      if (c < 0 || c > 63 || d > lim) break;
      exp_pg[nexp]  = pg;
      exp_ln[nexp]  = c;
      exp_llc[nexp] = force_llc || (d > 10);
      nexp++;
      n++;
    end
    ptr = base + n * s;
  endtask

  task automatic compare(input string req_n, input string req_v, input string req_l);
    chk(ncap == nexp, req_n, "prefetch count", ncap, nexp);
    for (int i = 0; i < ncap && i < nexp; i++) begin
      chk(cap_pg[i] == exp_pg[i] && cap_ln[i] == exp_ln[i], req_v, "prefetch line",
          cap_pg[i] * 64 + cap_ln[i], exp_pg[i] * 64 + exp_ln[i]);
      chk(cap_llc[i] == exp_llc[i], req_l, "llc_only flag", int'(cap_llc[i]), int'(exp_llc[i]));
    end
    ncap = 0;
    nexp = 0;
  endtask

  task automatic run_stream(input int start, input int s, input int cnt, input int outs,
                            input string req_v);
    int pg, ptr, L;
    string req_l;
    pg = next_pg++;
    ptr = 0;
    outstanding = 5'(outs);
    req_l = (outs < 4) ? "R9" : (outs < 12) ? "R7" : "R8";
    for (int k = 0; k < cnt; k++) begin
      L = start + k * s;
      demand(pg, L);
      if (k >= 1) model(pg, L, s, k >= 2, ptr);
      compare((k < 2) ? "R2" : ((s > 0) ? "R3" : "R4"), req_v, req_l);
    end
  endtask

  initial begin
    #(190000 * 5);
    miscmp++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", vectors, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    int pa, pf, pu, ptr_a, ptr_u, ptr_d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1
    chk(pf_valid == 1'b0, "R1", "pf_valid after reset", int'(pf_valid), 0);
    chk(dmd_ready == 1'b1, "R1", "dmd_ready after reset", int'(dmd_ready), 1);

    // Full-page sweeps over every load level, both directions (R6, R7, R8).
    for (int o = 0; o < 16; o++) begin
      run_stream(0, 1, 64, o, (o < 4) ? "R6" : (o < 12) ? "R7" : "R8");
      run_stream(63, -1, 64, o, (o < 4) ? "R6" : (o < 12) ? "R7" : "R8");
    end
    // Mid-page starts and page edges (R5).
    run_stream(30, 1, 20, 0, "R6");
    run_stream(30, -1, 20, 13, "R8");
    run_stream(58, 1, 6, 0, "R5");
    run_stream(5, -1, 6, 0, "R5");

    // R10: ascending and descending streams share one page.
    outstanding = 5'd0;
    pu = next_pg++;
    ptr_u = 0; ptr_d = 0;
    demand(pu, 20); compare("R10", "R10", "R9");
    demand(pu, 21); model(pu, 21, 1, 0, ptr_u); compare("R10", "R10", "R9");
    demand(pu, 40); compare("R10", "R10", "R9");
    demand(pu, 39); model(pu, 39, -1, 0, ptr_d); compare("R10", "R10", "R9");
    for (int k = 0; k < 4; k++) begin
      demand(pu, 22 + k); model(pu, 22 + k, 1, 1, ptr_u); compare("R10", "R10", "R9");
      demand(pu, 38 - k); model(pu, 38 - k, -1, 1, ptr_d); compare("R10", "R10", "R9");
    end

    // R11: a stream pushed out by four newer pages must retrain.
    pa = next_pg++;
    ptr_a = 0;
    demand(pa, 0); compare("R11", "R11", "R9");
    demand(pa, 1); model(pa, 1, 1, 0, ptr_a); compare("R11", "R11", "R9");
    for (int k = 0; k < 4; k++) begin demand(next_pg++, 10); compare("R11", "R11", "R9"); end
    demand(pa, 2); compare("R11", "R11", "R9");
    demand(pa, 3); ptr_a = 0; model(pa, 3, 1, 0, ptr_a); compare("R11", "R11", "R9");
    // R11 control: three newer pages leave the stream in place.
    pf = next_pg++;
    ptr_a = 0;
    demand(pf, 0); compare("R11", "R11", "R9");
    demand(pf, 1); model(pf, 1, 1, 0, ptr_a); compare("R11", "R11", "R9");
    for (int k = 0; k < 3; k++) begin demand(next_pg++, 10); compare("R11", "R11", "R9"); end
    demand(pf, 2); model(pf, 2, 1, 1, ptr_a); compare("R11", "R11", "R9");

    // R12: stalled output keeps four in order and drops the rest.
    pa = next_pg++;
    ptr_a = 0;
    pf_ready = 1'b0;
    demand(pa, 0);
    demand(pa, 1); model(pa, 1, 1, 0, ptr_a);
    demand(pa, 2); model(pa, 2, 1, 1, ptr_a);
    chk(pf_valid == 1'b1, "R12", "pf_valid while stalled", int'(pf_valid), 1);
    chk(int'(pf_addr[11:6]) == 2, "R12", "head line while stalled", int'(pf_addr[11:6]), 2);
    demand(pa, 3); model(pa, 3, 1, 1, ptr_a);
    chk(dmd_ready == 1'b1, "R12", "dmd_ready while stalled", int'(dmd_ready), 1);
    chk(int'(pf_addr[11:6]) == 2, "R12", "head line stable", int'(pf_addr[11:6]), 2);
    nexp = 4;
    @(posedge clk); #1 pf_ready = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    compare("R12", "R12", "R12");
    demand(pa, 4); model(pa, 4, 1, 1, ptr_a); compare("R12", "R12", "R12");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule